// File: doc/BRIEF.md
# Disk Sector Sequencer with End-of-Track Handling

This block keeps the current cylinder, head and sector of a floppy-style disk controller while a multi-sector read or write data command runs. A command is started from the idle state with a start address, the drive number, the multi-track setting, the sectors-per-track count and the highest cylinder. Once started, the DMA request enable is raised. Each pulse on `sec_done` reports that one 512-byte sector has moved, and the block then advances the address. Before the final sector of the track has moved, the block sets the end-of-track flag (ST1 bit 7). One more advance request while the flag is set aborts the command. A terminal-count stop is a normal termination, and if it happens on the last sector of the track, the pending advance is done in the build step.

The controller moves through four states. IDLE waits for `cmd_start` (IDLE to XFER). XFER advances on each `sec_done`, and leaves for BUILD on an abort or on terminal count (XFER to BUILD). BUILD lasts one cycle and applies the deferred advance (BUILD to RESULT). RESULT shows the seven-byte packet on `rd_byte` and returns to IDLE on `result_ack` (RESULT to IDLE). The spt, max_cyl, drive and multi-track values are sampled at `cmd_start`.

Top module: `sector_seq`

## Requirements
- R1: After reset, st0, st1, st2, cur_cyl, cur_head, cur_sec, drq_en and res_req are all 0, and the block is idle.
- R2: A cmd_start in IDLE loads start_cyl, start_head and start_sec into the current address and raises drq_en in the next cycle. st0 keeps its previous value.
- R3: A sec_done in XFER with tc low and ST1 bit 7 clear advances the address. If the sector is below spt, the sector increments. Otherwise the sector becomes 1, and then one of two things happens. With multi-track set, the head toggles, and the cylinder increments only when the head goes from 1 to 0. With multi-track clear, the head is unchanged and the cylinder increments.
- R4: A cylinder increment never takes the cylinder above max_cyl. At max_cyl the cylinder holds.
- R5: After an advance, ST1 bit 7 (end of track) is set when the new head equals the multi-track bit and the new sector equals spt. Otherwise ST1 stays 0.
- R6: A sec_done with tc low while ST1 bit 7 is set does not advance the address. It sets st0 = 0x40 | head<<2 | drive, clears drq_en and leaves XFER. ST1 keeps 0x80.
- R7: A sec_done with tc high sets st0 = head<<2 | drive and st2 = 0. It clears drq_en and leaves XFER. It does not advance the address at that edge, and ST1 is not cleared.
- R8: In the build step, if st0 bits 7:6 are 00 and ST1 bit 7 is set, ST1 bit 7 clears. The address then advances once by the R3/R4 rules, and st0 bit 2 takes the new head.
- R9: In RESULT, rd_byte gives the packet byte selected by rd_idx. Index 0 is st0, 1 is st1, 2 is st2, 3 is the cylinder, 4 is the head, 5 is the sector, and 6 is the size code 2 (512-byte sectors). Index 7 reads 0.
- R10: res_req is high for exactly one cycle. It rises in the second cycle after the terminating sec_done edge, with the packet already final.
- R11: result_ack in RESULT returns the block to IDLE and clears st1 and st2. st0 is left unchanged.
- R12: sec_done has no effect outside XFER. The address, status and packet do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_start | input | 1 | Start a data command (IDLE only) |
| drive_sel | input | 2 | Drive number, sampled at start |
| multi_trk | input | 1 | Multi-track setting, sampled at start |
| start_cyl | input | 8 | Start cylinder |
| start_head | input | 1 | Start head |
| start_sec | input | 8 | Start sector (1-based) |
| spt | input | 8 | Sectors per track, sampled at start |
| max_cyl | input | 8 | Highest cylinder, sampled at start |
| sec_done | input | 1 | One sector transferred |
| tc | input | 1 | Terminal-count level |
| result_ack | input | 1 | Packet consumed, return to idle |
| rd_idx | input | 3 | Packet byte select |
| rd_byte | output | 8 | Selected packet byte |
| st0 | output | 8 | Status 0 |
| st1 | output | 8 | Status 1 (bit 7 end of track) |
| st2 | output | 8 | Status 2 |
| cur_cyl | output | 8 | Current cylinder |
| cur_head | output | 1 | Current head |
| cur_sec | output | 8 | Current sector |
| drq_en | output | 1 | DMA request enable |
| res_req | output | 1 | Result-phase request pulse |

## Verification
Every register change appears on the ports one edge after its cause. A wrong sector, head or cylinder step shows on cur_sec, cur_head and cur_cyl right after the sec_done that caused it. An end-of-track flag latched a sector too late or too early shows on st1 at once. Two later faults show on the packet and on res_req two cycles after the terminating pulse: a missed or doubled deferred advance, and a wrong abort/normal choice.

// File: rtl/sector_seq_pkg.sv
package sector_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_XFER,
        ST_BUILD,
        ST_RESULT
    } seq_state_t;

    localparam int          EOT_BIT       = 7;
    localparam logic [1:0]  TERM_NORMAL   = 2'b00;
    localparam logic [1:0]  TERM_ABORT    = 2'b01;
    localparam logic [7:0]  SIZE_CODE_512 = 8'd2;
    localparam int          PKT_LEN       = 7;

endpackage

// File: rtl/sector_step.sv
module sector_step #(
    parameter int CYL_W = 8,
    parameter int SEC_W = 8
) (
    input  logic [CYL_W-1:0] cyl,
    input  logic             head,
    input  logic [SEC_W-1:0] sec,
    input  logic             mt,
    input  logic [SEC_W-1:0] spt,
    input  logic [CYL_W-1:0] max_cyl,
    output logic [CYL_W-1:0] nxt_cyl,
    output logic             nxt_head,
    output logic [SEC_W-1:0] nxt_sec,
    output logic             nxt_eot
);

    logic wrap;
    logic bump_cyl;

    always_comb begin
        wrap     = (sec >= spt);
        bump_cyl = wrap && (!mt || head);
        nxt_sec  = wrap ? SEC_W'(1) : sec + SEC_W'(1);
        nxt_head = (wrap && mt) ? ~head : head;
        nxt_cyl  = (bump_cyl && (cyl < max_cyl)) ? cyl + CYL_W'(1) : cyl;
        nxt_eot  = (nxt_head == mt) && (nxt_sec == spt);
    end

endmodule

// File: rtl/result_mux.sv
module result_mux
    import sector_seq_pkg::*;
#(
    parameter int CYL_W = 8,
    parameter int SEC_W = 8,
    parameter int IDX_W = 3
) (
    input  logic [7:0]       st0,
    input  logic [7:0]       st1,
    input  logic [7:0]       st2,
    input  logic [CYL_W-1:0] cyl,
    input  logic             head,
    input  logic [SEC_W-1:0] sec,
    input  logic [IDX_W-1:0] idx,
    output logic [7:0]       byte_o
);

    localparam int SLOTS = 1 << IDX_W;

    logic [7:0] slot [SLOTS];

    assign slot[0] = st0;
    assign slot[1] = st1;
    assign slot[2] = st2;
    assign slot[3] = 8'(cyl);
    assign slot[4] = {7'd0, head};
    assign slot[5] = 8'(sec);
    assign slot[6] = SIZE_CODE_512;

    generate
        for (genvar g = PKT_LEN; g < SLOTS; g++) begin : g_pad
            assign slot[g] = 8'h00;
        end
    endgenerate

    assign byte_o = slot[idx];

endmodule

// File: rtl/sector_seq.sv
module sector_seq
    import sector_seq_pkg::*;
#(
    parameter int CYL_W = 8,
    parameter int SEC_W = 8,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_start,
    input  logic [1:0]       drive_sel,
    input  logic             multi_trk,
    input  logic [CYL_W-1:0] start_cyl,
    input  logic             start_head,
    input  logic [SEC_W-1:0] start_sec,
    input  logic [SEC_W-1:0] spt,
    input  logic [CYL_W-1:0] max_cyl,
    input  logic             sec_done,
    input  logic             tc,
    input  logic             result_ack,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [7:0]       rd_byte,
    output logic [7:0]       st0,
    output logic [7:0]       st1,
    output logic [7:0]       st2,
    output logic [CYL_W-1:0] cur_cyl,
    output logic             cur_head,
    output logic [SEC_W-1:0] cur_sec,
    output logic             drq_en,
    output logic             res_req
);

    seq_state_t state_q, state_d;

    logic [CYL_W-1:0] cyl_q, max_q;
    logic             head_q, mt_q;
    logic [SEC_W-1:0] sec_q, spt_q;
    logic [1:0]       drv_q;
    logic [7:0]       st0_q, st1_q, st2_q;
    logic             drq_q, req_q;

    logic [CYL_W-1:0] step_cyl;
    logic             step_head;
    logic [SEC_W-1:0] step_sec;
    logic             step_eot;

    logic adv_req, eot_now, abort_hit, finish_hit, plain_adv, defer_adv;

    sector_step #(.CYL_W(CYL_W), .SEC_W(SEC_W)) u_step (
        .cyl      (cyl_q),
        .head     (head_q),
        .sec      (sec_q),
        .mt       (mt_q),
        .spt      (spt_q),
        .max_cyl  (max_q),
        .nxt_cyl  (step_cyl),
        .nxt_head (step_head),
        .nxt_sec  (step_sec),
        .nxt_eot  (step_eot)
    );

    result_mux #(.CYL_W(CYL_W), .SEC_W(SEC_W), .IDX_W(IDX_W)) u_pkt (
        .st0    (st0_q),
        .st1    (st1_q),
        .st2    (st2_q),
        .cyl    (cyl_q),
        .head   (head_q),
        .sec    (sec_q),
        .idx    (rd_idx),
        .byte_o (rd_byte)
    );

    always_comb begin
        adv_req    = (state_q == ST_XFER) && sec_done;
        eot_now    = st1_q[EOT_BIT];
        abort_hit  = adv_req && !tc && eot_now;
        finish_hit = adv_req && tc;
        plain_adv  = adv_req && !tc && !eot_now;
        defer_adv  = (state_q == ST_BUILD) && (st0_q[7:6] == TERM_NORMAL) && eot_now;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (cmd_start)               state_d = ST_XFER;
            ST_XFER:   if (abort_hit || finish_hit) state_d = ST_BUILD;
            ST_BUILD:                               state_d = ST_RESULT;
            ST_RESULT: if (result_ack)              state_d = ST_IDLE;
            default:                                state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyl_q  <= '0;
            head_q <= 1'b0;
            sec_q  <= '0;
            drv_q  <= 2'd0;
            mt_q   <= 1'b0;
            spt_q  <= '0;
            max_q  <= '0;
            st0_q  <= 8'h00;
            st1_q  <= 8'h00;
            st2_q  <= 8'h00;
            drq_q  <= 1'b0;
            req_q  <= 1'b0;
        end else begin
            req_q <= (state_q == ST_BUILD);
            unique case (state_q)
                ST_IDLE: begin
                    if (cmd_start) begin
                        cyl_q  <= start_cyl;
                        head_q <= start_head;
                        sec_q  <= start_sec;
                        drv_q  <= drive_sel;
                        mt_q   <= multi_trk;
                        spt_q  <= spt;
                        max_q  <= max_cyl;
                        drq_q  <= 1'b1;
                    end
                end
                ST_XFER: begin
                    if (plain_adv) begin
                        cyl_q  <= step_cyl;
                        head_q <= step_head;
                        sec_q  <= step_sec;
                        if (step_eot) st1_q[EOT_BIT] <= 1'b1;
                    end else if (abort_hit) begin
                        st0_q <= {TERM_ABORT, 3'b000, head_q, drv_q};
                        drq_q <= 1'b0;
                    end else if (finish_hit) begin
                        st0_q <= {TERM_NORMAL, 3'b000, head_q, drv_q};
                        st2_q <= 8'h00;
                        drq_q <= 1'b0;
                    end
                end
                ST_BUILD: begin
                    if (defer_adv) begin
                        cyl_q          <= step_cyl;
                        head_q         <= step_head;
                        sec_q          <= step_sec;
                        st1_q[EOT_BIT] <= 1'b0;
                        st0_q[2]       <= step_head;
                    end
                end
                ST_RESULT: begin
                    if (result_ack) begin
                        st1_q <= 8'h00;
                        st2_q <= 8'h00;
                    end
                end
                default: ;
            endcase
        end
    end

    assign st0      = st0_q;
    assign st1      = st1_q;
    assign st2      = st2_q;
    assign cur_cyl  = cyl_q;
    assign cur_head = head_q;
    assign cur_sec  = sec_q;
    assign drq_en   = drq_q;
    assign res_req  = req_q;

    // R10
    req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_req |=> !res_req);

    // R6
    abort_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort_hit |=> (st0[7:6] == TERM_ABORT) && !drq_en && (cur_sec == $past(sec_q)) && st1[EOT_BIT]);

    // R7
    finish_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        finish_hit |=> (st0[7:6] == TERM_NORMAL) && !drq_en && (st2 == 8'h00));

    // R4
    cyl_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (plain_adv && (cyl_q >= max_q)) |=> (cur_cyl == $past(cyl_q)));

    // R11
    idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RESULT && result_ack) |=> (st1 == 8'h00) && (st2 == 8'h00) && $stable(st0));

    // R12
    hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RESULT && !result_ack) |=> $stable(cur_sec) && $stable(cur_cyl) && $stable(st1));

endmodule

// File: tb/sector_seq_test.sv
module sector_seq_test;

    localparam int SPT  = 3;
    localparam int MAXC = 1;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_start = 1'b0;
    logic [1:0] drive_sel = 2'd0;
    logic       multi_trk = 1'b0;
    logic [7:0] start_cyl = 8'd0;
    logic       start_head = 1'b0;
    logic [7:0] start_sec = 8'd1;
    logic [7:0] spt = 8'(SPT);
    logic [7:0] max_cyl = 8'(MAXC);
    logic       sec_done = 1'b0;
    logic       tc = 1'b0;
    logic       result_ack = 1'b0;
    logic [2:0] rd_idx = 3'd0;
    logic [7:0] rd_byte, st0, st1, st2, cur_cyl, cur_sec;
    logic       cur_head, drq_en, res_req;

    int n_cmp = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    sector_seq uut (
        .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .drive_sel(drive_sel),
        .multi_trk(multi_trk), .start_cyl(start_cyl), .start_head(start_head),
        .start_sec(start_sec), .spt(spt), .max_cyl(max_cyl), .sec_done(sec_done),
        .tc(tc), .result_ack(result_ack), .rd_idx(rd_idx), .rd_byte(rd_byte),
        .st0(st0), .st1(st1), .st2(st2), .cur_cyl(cur_cyl), .cur_head(cur_head),
        .cur_sec(cur_sec), .drq_en(drq_en), .res_req(res_req)
    );

    task automatic cmp(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic step_model(inout int c, inout int h, inout int s, input int mt, output bit eot);
        if (s >= SPT) begin
            s = 1;
            if (mt != 0) begin
                if (h == 1 && c < MAXC) c++;
                h = 1 - h;
            end else if (c < MAXC) begin
                c++;
            end
        end else begin
            s++;
        end
        eot = (h == mt) && (s == SPT);
    endtask

    task automatic run_case(input int mt, input int h0, input int s0, input int c0,
                            input int n, input int drv, inout int prev_st0);
        int  c = c0, h = h0, s = s0;
        bit  eot = 0;
        bit  aborted = 0;
        int  e0, e1;
        @(negedge clk);
        multi_trk = mt[0]; start_head = h0[0]; start_sec = 8'(s0);
        start_cyl = 8'(c0); drive_sel = drv[1:0]; cmd_start = 1'b1;
        @(negedge clk);
        cmd_start = 1'b0;
        cmp("R2 drq_en", {7'd0, drq_en}, 8'd1);
        cmp("R2 cur_sec", cur_sec, 8'(s));
        cmp("R2 cur_head", {7'd0, cur_head}, 8'(h));
        cmp("R2 cur_cyl", cur_cyl, 8'(c));
        cmp("R2 st0 kept", st0, 8'(prev_st0));
        for (int k = 1; k <= n; k++) begin
            sec_done = 1'b1; tc = (k == n);
            @(negedge clk);
            sec_done = 1'b0; tc = 1'b0;
            if (k == n) break;
            if (eot) begin
                aborted = 1;
                break;
            end
            step_model(c, h, s, mt, eot);
            cmp("R3 sector", cur_sec, 8'(s));
            cmp("R3 head", {7'd0, cur_head}, 8'(h));
            cmp("R4 cylinder", cur_cyl, 8'(c));
            cmp("R5 st1", st1, eot ? 8'h80 : 8'h00);
        end
        cmp(aborted ? "R6 drq_en" : "R7 drq_en", {7'd0, drq_en}, 8'd0);
        if (aborted) begin
            e0 = 32'h40 | (h << 2) | drv;
            cmp("R6 st0", st0, 8'(e0));
            cmp("R6 sector held", cur_sec, 8'(s));
            e1 = 32'h80;
        end else begin
            e0 = (h << 2) | drv;
            cmp("R7 st0", st0, 8'(e0));
            cmp("R7 st2", st2, 8'h00);
            cmp("R7 st1 kept", st1, eot ? 8'h80 : 8'h00);
            if (eot) begin
                bit dummy;
                step_model(c, h, s, mt, dummy);
                e0 = (h << 2) | drv;
            end
            e1 = 0;
        end
        @(negedge clk);
        cmp("R10 res_req high", {7'd0, res_req}, 8'd1);
        for (int i = 0; i < 8; i++) begin
            logic [7:0] exp;
            rd_idx = 3'(i);
            #1;
            case (i)
                0: exp = 8'(e0);
                1: exp = 8'(e1);
                2: exp = 8'h00;
                3: exp = 8'(c);
                4: exp = 8'(h);
                5: exp = 8'(s);
                6: exp = 8'd2;
                default: exp = 8'h00;
            endcase
            cmp(eot && !aborted ? "R8 packet" : "R9 packet", rd_byte, exp);
        end
        @(negedge clk);
        cmp("R10 res_req low", {7'd0, res_req}, 8'd0);
        sec_done = 1'b1;
        @(negedge clk);
        sec_done = 1'b0;
        @(negedge clk);
        cmp("R12 sector", cur_sec, 8'(s));
        cmp("R12 st1", st1, 8'(e1));
        result_ack = 1'b1;
        @(negedge clk);
        result_ack = 1'b0;
        cmp("R11 st1", st1, 8'h00);
        cmp("R11 st2", st2, 8'h00);
        cmp("R11 st0", st0, 8'(e0));
        sec_done = 1'b1;
        @(negedge clk);
        sec_done = 1'b0;
        cmp("R12 idle sector", cur_sec, 8'(s));
        prev_st0 = e0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : main
        int prev = 0;
        int idx = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        cmp("R1 st0", st0, 8'h00);
        cmp("R1 st1", st1, 8'h00);
        cmp("R1 st2", st2, 8'h00);
        cmp("R1 cur_cyl", cur_cyl, 8'h00);
        cmp("R1 cur_sec", cur_sec, 8'h00);
        cmp("R1 cur_head", {7'd0, cur_head}, 8'h00);
        cmp("R1 drq_en", {7'd0, drq_en}, 8'h00);
        cmp("R1 res_req", {7'd0, res_req}, 8'h00);
        for (int mt = 0; mt < 2; mt++)
            for (int h0 = 0; h0 < 2; h0++)
                for (int s0 = 1; s0 <= SPT; s0++)
                    for (int n = 1; n <= 6; n++) begin
                        run_case(mt, h0, s0, idx % 2, n, idx % 4, prev);
                        idx++;
                    end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule